// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block is a multiply-accumulate datapath that accepts one operand pair on every clock. A per-operation select picks a 16x16 multiply on the low halves of the operands or a full 32x32 multiply. The operands are treated as signed integers, unsigned integers or signed fixed-point fractions. The product is then used in one of three ways: it replaces the 48-bit accumulator, it is added to it, or it is subtracted from it.

The work is spread over four register stages: operand capture, product, alignment and accumulate. The accumulate stage updates the accumulator in one cycle, so dependent operations can follow each other on every clock without stalling. A sticky flag records any overflow of the 48-bit result. An optional saturate setting, sampled with each operation, clamps an overflowed result to the nearest representable value. A register-move port lets surrounding logic read the accumulator at any time and load it with a new value.

Top module: `mac_unit`

## Requirements
- R1: While reset (rstN low) is asserted, the accumulator output reads zero and the overflow flag reads 0.
- R2: An operation sampled with opValid high at clock edge k changes accOut at edge k+3, and not before. Operations issued on consecutive clocks each build on the result of the one before, with no stall.
- R3: With opWide=0, only bits [15:0] of opA and opB take part in the multiply, and the upper bits have no effect. With opWide=1, all 32 bits take part.
- R4: With opFmt=00 the operands are two's-complement signed integers, and the operand for the accumulate step is the low 48 bits of the full signed product.
- R5: With opFmt=01 the operands are unsigned integers, and the operand for the accumulate step is the low 48 bits of the unsigned product.
- R6: With opFmt=10 or 11 the operands are signed fractions. The signed product is shifted left by one bit before its low 48 bits are taken.
- R7: opCode selects what happens to the accumulator: 00 loads the product, 01 adds the product, 10 subtracts the product, and 11 leaves the accumulator unchanged.
- R8: ovfFlag is sticky. It sets when an add or subtract overflows 48 bits: as signed two's complement for opFmt 00, 10 and 11, or as an unsigned carry or borrow for opFmt 01. A load never sets it or clears it.
- R9: When an operation sampled with satEn=1 overflows, the accumulator takes a clamped value. Signed results clamp to 48'h7FFF_FFFF_FFFF or 48'h8000_0000_0000. An unsigned add clamps to all ones, and an unsigned subtract clamps to zero. The flag still sets.
- R10: When accWrEn is high at an edge, the accumulator takes accWrData and the flag clears at that edge. This write wins over an operation retiring on the same edge, and accOut always shows the current accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Issue an operation this cycle |
| opCode | input | 2 | 00 load, 01 add, 10 subtract, 11 hold |
| opFmt | input | 2 | 00 signed, 01 unsigned, 1x signed fraction |
| opWide | input | 1 | 1 selects 32x32, 0 selects 16x16 on the low halves |
| satEn | input | 1 | Clamp this operation on overflow |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| accWrEn | input | 1 | Load the accumulator from accWrData |
| accWrData | input | 48 | Accumulator write value |
| accOut | output | 48 | Current accumulator |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
Operation results are due three edges after the edge that samples the operation. Register-move writes are due one edge after they are sampled. The bench reference model delays each operation through a three-slot history and retires it on the matching edge, applying a same-edge write first. It then compares accOut and ovfFlag at every falling edge, after the design's registers have settled. The directed checks for latency and chaining sample at the third and fourth falling edges after issue, which shows that the result does not arrive early.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OP_W  = 32;
  localparam int ACC_W = 48;

  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_HOLD = 2'b11
  } macOp_e;

  typedef enum logic [1:0] {
    FMT_SINT  = 2'b00,
    FMT_UINT  = 2'b01,
    FMT_FRAC  = 2'b10,
    FMT_FRAC2 = 2'b11
  } macFmt_e;

  typedef struct packed {
    logic   valid;
    macOp_e op;
    logic   isUnsigned;
    logic   isFrac;
    logic   wide;
    logic   sat;
  } ctrlStage_t;

  typedef struct packed {
    logic extUnsigned;
    logic extWide;
    logic fracShift;
    logic accLoad;
    logic accAdd;
    logic accSub;
    logic accUnsigned;
    logic accSat;
    logic accWr;
  } macStrobe_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opCode,
  input  logic [1:0] opFmt,
  input  logic       opWide,
  input  logic       satEn,
  input  logic       accWrEn,
  output macStrobe_t strobe
);
  localparam int LAST = STAGES - 1;

  ctrlStage_t stg [STAGES];
  ctrlStage_t inStage;

  always_comb begin
    inStage.valid      = opValid;
    inStage.op         = macOp_e'(opCode);
    inStage.isUnsigned = (opFmt == FMT_UINT);
    inStage.isFrac     = opFmt[1];
    inStage.wide       = opWide;
    inStage.sat        = satEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= inStage;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  always_comb begin
    strobe.extUnsigned = stg[0].isUnsigned;
    strobe.extWide     = stg[0].wide;
    strobe.fracShift   = stg[1].isFrac;
    strobe.accLoad     = stg[LAST].valid && (stg[LAST].op == OP_LOAD);
    strobe.accAdd      = stg[LAST].valid && (stg[LAST].op == OP_ADD);
    strobe.accSub      = stg[LAST].valid && (stg[LAST].op == OP_SUB);
    strobe.accUnsigned = stg[LAST].isUnsigned;
    strobe.accSat      = stg[LAST].sat;
    strobe.accWr       = accWrEn;
  end

  // R7: at most one accumulator action per cycle
  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.accLoad, strobe.accAdd, strobe.accSub}));

  // R2: each stage holds a valid op only if the stage before held one a cycle earlier
  assert_stage_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    stg[1].valid |-> $past(stg[0].valid));

  assert_issue_enters_R2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> stg[0].valid);
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int ACCW = ACC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OPW-1:0]    opA,
  input  logic [OPW-1:0]    opB,
  input  logic [ACCW-1:0]   accWrData,
  input  macStrobe_t        strobe,
  output logic [ACCW-1:0]   accOut,
  output logic              ovfFlag
);
  localparam int HALFW = OPW / 2;
  localparam int EXTW  = OPW + 1;
  localparam int FULLW = 2 * EXTW;
  localparam int PRODW = 2 * OPW;
  localparam logic [ACCW-1:0] SMAX = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic [ACCW-1:0] SMIN = {1'b1, {(ACCW-1){1'b0}}};

  logic [OPW-1:0]   s1A, s1B;
  logic [PRODW-1:0] s2Prod;
  logic [ACCW-1:0]  s3Add;
  logic [ACCW-1:0]  accReg;
  logic             ovfReg;

  // stage 1: operand capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1A <= '0;
      s1B <= '0;
    end else begin
      s1A <= opA;
      s1B <= opB;
    end
  end

  // stage 2: operand extension and multiply
  logic [EXTW-1:0]         extA, extB;
  logic signed [FULLW-1:0] prodFull;

  function automatic logic [EXTW-1:0] extendOp(input logic [OPW-1:0] v,
                                               input logic wide,
                                               input logic uns);
    logic [EXTW-1:0] r;
    if (wide) r = {(uns ? 1'b0 : v[OPW-1]), v};
    else      r = {{(EXTW-HALFW){uns ? 1'b0 : v[HALFW-1]}}, v[HALFW-1:0]};
    return r;
  endfunction

  always_comb begin
    extA     = extendOp(s1A, strobe.extWide, strobe.extUnsigned);
    extB     = extendOp(s1B, strobe.extWide, strobe.extUnsigned);
    prodFull = $signed(extA) * $signed(extB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) s2Prod <= '0;
    else       s2Prod <= prodFull[PRODW-1:0];
  end

  // stage 3: fractional alignment
  logic [PRODW-1:0] aligned;
  always_comb aligned = strobe.fracShift ? {s2Prod[PRODW-2:0], 1'b0} : s2Prod;

  always_ff @(posedge clk) begin
    if (!rstN) s3Add <= '0;
    else       s3Add <= aligned[ACCW-1:0];
  end

  // stage 4: accumulate
  logic [ACCW:0]   accExt, addExt, sumExt;
  logic            sumOvf;
  logic [ACCW-1:0] clampVal, accNext;

  always_comb begin
    accExt = strobe.accUnsigned ? {1'b0, accReg} : {accReg[ACCW-1], accReg};
    addExt = strobe.accUnsigned ? {1'b0, s3Add}  : {s3Add[ACCW-1], s3Add};
    sumExt = strobe.accSub ? (accExt - addExt) : (accExt + addExt);
    if (strobe.accUnsigned) sumOvf = sumExt[ACCW];
    else                    sumOvf = sumExt[ACCW] ^ sumExt[ACCW-1];
    if (strobe.accUnsigned) clampVal = strobe.accSub ? '0 : '1;
    else                    clampVal = sumExt[ACCW] ? SMIN : SMAX;
    accNext = (sumOvf && strobe.accSat) ? clampVal : sumExt[ACCW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg <= '0;
      ovfReg <= 1'b0;
    end else if (strobe.accWr) begin
      accReg <= accWrData;
      ovfReg <= 1'b0;
    end else if (strobe.accLoad) begin
      accReg <= s3Add;
    end else if (strobe.accAdd || strobe.accSub) begin
      accReg <= accNext;
      ovfReg <= ovfReg | sumOvf;
    end
  end

  assign accOut  = accReg;
  assign ovfFlag = ovfReg;

  // R10: a register write lands on the next edge and clears the flag
  assert_wr_loads_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accWr |=> (accReg == $past(accWrData)) && !ovfReg);

  // R8: flag only falls through a register write
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfReg) |-> $past(strobe.accWr));

  // R8: a load never changes the flag
  assert_load_keeps_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accLoad && !strobe.accWr) |=> $stable(ovfReg));

  // R7: without any action the accumulator holds
  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.accWr || strobe.accLoad || strobe.accAdd || strobe.accSub) |=> $stable(accReg));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int ACCW = ACC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [1:0]      opCode,
  input  logic [1:0]      opFmt,
  input  logic            opWide,
  input  logic            satEn,
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  input  logic            accWrEn,
  input  logic [ACCW-1:0] accWrData,
  output logic [ACCW-1:0] accOut,
  output logic            ovfFlag
);
  macStrobe_t strobe;

  mac_ctrl #(.STAGES(3)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .opFmt   (opFmt),
    .opWide  (opWide),
    .satEn   (satEn),
    .accWrEn (accWrEn),
    .strobe  (strobe)
  );

  mac_datapath #(.OPW(OPW), .ACCW(ACCW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .accWrData (accWrData),
    .strobe    (strobe),
    .accOut    (accOut),
    .ovfFlag   (ovfFlag)
  );
endmodule

// File: tb/mac_unit_tb.sv
module mac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = 2'b00;
  logic [1:0]  opFmt = 2'b00;
  logic        opWide = 1'b0;
  logic        satEn = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        accWrEn = 1'b0;
  logic [47:0] accWrData = '0;
  logic [47:0] accOut;
  logic        ovfFlag;

  int compared = 0;
  int mismatched = 0;
  string curTag = "R1";
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  mac_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opFmt(opFmt),
    .opWide(opWide), .satEn(satEn), .opA(opA), .opB(opB), .accWrEn(accWrEn),
    .accWrData(accWrData), .accOut(accOut), .ovfFlag(ovfFlag)
  );

  typedef struct {
    bit valid; bit [1:0] op; bit [1:0] fmt; bit wide; bit sat;
    bit [31:0] a; bit [31:0] b;
  } opRec_t;

  opRec_t hist[3];
  bit [47:0] mAcc = '0;
  bit        mOvf = 0;

  function automatic bit [47:0] productOf(opRec_t r);
    longint p;
    longint unsigned pu;
    if (r.fmt == 2'b01) begin
      longint unsigned ua = r.wide ? 64'(r.a) : 64'(r.a[15:0]);
      longint unsigned ub = r.wide ? 64'(r.b) : 64'(r.b[15:0]);
      pu = ua * ub;
      return pu[47:0];
    end else begin
      longint sa = r.wide ? longint'($signed(r.a)) : longint'($signed(r.a[15:0]));
      longint sb = r.wide ? longint'($signed(r.b)) : longint'($signed(r.b[15:0]));
      p = sa * sb;
      if (r.fmt[1]) p = p <<< 1;
      return p[47:0];
    end
  endfunction

  task automatic retire(opRec_t r);
    bit [47:0] pr;
    longint s;
    bit ov;
    if (!r.valid || r.op == 2'b11) return;
    pr = productOf(r);
    if (r.op == 2'b00) begin mAcc = pr; return; end
    if (r.fmt == 2'b01) begin
      s = (r.op == 2'b01) ? longint'({16'h0, mAcc}) + longint'({16'h0, pr})
                          : longint'({16'h0, mAcc}) - longint'({16'h0, pr});
      ov = (s < 0) || (s > 64'sh0000_FFFF_FFFF_FFFF);
      if (ov && r.sat) mAcc = (r.op == 2'b01) ? 48'hFFFF_FFFF_FFFF : 48'h0;
      else mAcc = s[47:0];
    end else begin
      longint x = longint'($signed(mAcc));
      longint y = longint'($signed(pr));
      s = (r.op == 2'b01) ? x + y : x - y;
      ov = (s > 64'sh0000_7FFF_FFFF_FFFF) || (s < -64'sh0000_8000_0000_0000);
      if (ov && r.sat) mAcc = (s < 0) ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF;
      else mAcc = s[47:0];
    end
    if (ov) mOvf = 1;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mAcc = '0; mOvf = 0;
      for (int i = 0; i < 3; i++) hist[i] = '{default: 0};
    end else begin
      if (accWrEn) begin mAcc = accWrData; mOvf = 0; end
      else retire(hist[2]);
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = '{opValid, opCode, opFmt, opWide, satEn, opA, opB};
    end
  end

  task automatic check48(string tag, bit [47:0] act, bit [47:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (!done) begin
      check48({curTag, " model acc"}, accOut, rstN ? mAcc : 48'h0);
      check48({curTag, " model ovf"}, 48'(ovfFlag), rstN ? 48'(mOvf) : 48'h0);
    end
  end

  task automatic idle();
    opValid = 0; accWrEn = 0;
  endtask

  task automatic issue(bit [1:0] op, bit [1:0] fmt, bit wide, bit sat,
                       bit [31:0] a, bit [31:0] b);
    opValid = 1; opCode = op; opFmt = fmt; opWide = wide; satEn = sat;
    opA = a; opB = b;
    @(negedge clk);
    opValid = 0;
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeAcc(bit [47:0] v);
    accWrEn = 1; accWrData = v;
    @(negedge clk);
    accWrEn = 0;
  endtask

  task automatic runOp(bit [1:0] op, bit [1:0] fmt, bit wide, bit sat,
                       bit [31:0] a, bit [31:0] b);
    issue(op, fmt, wide, sat, a, b);
    waitN(3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    curTag = "R1";
    check48("R1 reset acc", accOut, 48'h0);
    check48("R1 reset ovf", 48'(ovfFlag), 48'h0);
    rstN = 1;
    @(negedge clk);
    check48("R1 after release", accOut, 48'h0);

    curTag = "R3";
    runOp(2'b00, 2'b00, 0, 0, 32'hABCD_FFFD, 32'h1234_0005);
    check48("R3 R4 narrow signed load", accOut, 48'hFFFF_FFFF_FFF1);

    curTag = "R5";
    runOp(2'b00, 2'b01, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check48("R5 unsigned wide", accOut, 48'hFFFE_0000_0001);

    curTag = "R6";
    runOp(2'b00, 2'b10, 0, 0, 32'h0000_4000, 32'h0000_4000);
    check48("R6 fraction shift", accOut, 48'h0000_2000_0000);

    curTag = "R7";
    runOp(2'b01, 2'b00, 1, 0, 32'd2, 32'd3);
    check48("R7 add", accOut, 48'h0000_2000_0006);
    runOp(2'b10, 2'b00, 0, 0, 32'd1, 32'd6);
    check48("R7 subtract", accOut, 48'h0000_2000_0000);
    runOp(2'b11, 2'b00, 1, 0, 32'd9, 32'd9);
    check48("R7 hold", accOut, 48'h0000_2000_0000);

    curTag = "R8";
    writeAcc(48'h7FFF_FFFF_FFFF);
    check48("R10 write lands", accOut, 48'h7FFF_FFFF_FFFF);
    runOp(2'b01, 2'b00, 1, 0, 32'd1, 32'd1);
    check48("R8 wrap value", accOut, 48'h8000_0000_0000);
    check48("R8 flag set", 48'(ovfFlag), 48'h1);
    runOp(2'b00, 2'b00, 1, 0, 32'd5, 32'd1);
    check48("R8 load keeps flag", 48'(ovfFlag), 48'h1);

    curTag = "R9";
    writeAcc(48'h7FFF_FFFF_FFFF);
    check48("R10 write clears flag", 48'(ovfFlag), 48'h0);
    runOp(2'b01, 2'b00, 1, 1, 32'd1, 32'd1);
    check48("R9 signed clamp high", accOut, 48'h7FFF_FFFF_FFFF);
    check48("R9 flag with sat", 48'(ovfFlag), 48'h1);
    writeAcc(48'h0);
    runOp(2'b10, 2'b01, 1, 1, 32'd1, 32'd1);
    check48("R9 unsigned borrow clamp", accOut, 48'h0);
    check48("R8 unsigned borrow flag", 48'(ovfFlag), 48'h1);

    curTag = "R10";
    writeAcc(48'h0000_0000_0010);
    issue(2'b01, 2'b00, 1, 0, 32'd4, 32'd4);
    waitN(2);
    accWrEn = 1; accWrData = 48'h0000_0ABC_0000;
    @(negedge clk);
    accWrEn = 0;
    check48("R10 write wins", accOut, 48'h0000_0ABC_0000);

    curTag = "R2";
    writeAcc(48'h0);
    opValid = 1; opCode = 2'b01; opFmt = 2'b00; opWide = 1; satEn = 0;
    opA = 32'd1; opB = 32'd1;
    waitN(3);
    opValid = 0;
    check48("R2 not early", accOut, 48'h0);
    @(negedge clk); check48("R2 first", accOut, 48'h1);
    @(negedge clk); check48("R2 chained", accOut, 48'h2);
    @(negedge clk); check48("R2 chained third", accOut, 48'h3);

    curTag = "R2 random";
    for (int i = 0; i < 600; i++) begin
      opValid = ($urandom_range(0, 3) != 0);
      opCode = 2'($urandom());
      opFmt = 2'($urandom());
      opWide = 1'($urandom());
      satEn = 1'($urandom());
      opA = (i % 7 == 0) ? 32'h8000_0000 : $urandom();
      opB = (i % 5 == 0) ? 32'h7FFF_FFFF : $urandom();
      accWrEn = ($urandom_range(0, 15) == 0);
      accWrData = {16'($urandom()), 32'($urandom())};
      @(negedge clk);
    end
    idle();
    waitN(5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1;
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule